// File: doc/BRIEF.md
# Real-Time Clock Register Block with Tear-Free Time Reads

This peripheral keeps wall-clock time in a seconds counter and a sub-second counter that both run in the bus clock domain. They advance on edges of a slow reference clock. That input is asynchronous. It is brought into the bus domain through a flop synchronizer, and each rising edge gives one slow tick. A fractional divider turns slow ticks into millisecond steps. It uses 32 or 33 slow ticks per step, so that the long-run rate averages 32.768 ticks per millisecond. The millisecond count rolls over from the top of its range to zero, and the seconds counter advances on that same cycle.

Software does not read the running counters directly. After every eighth slow tick the block opens a short copy window, and the busy flag is high for that window. At the end of the window the running counters are copied into visible registers. Writes made while busy is high are dropped. Reads are always allowed. Reading the millisecond register also captures the visible seconds value into a shadow register, so a later read of the shadow returns seconds that match the millisecond value just read. Two seconds alarms and one millisecond alarm set bits in a sticky status register. Software clears those bits by writing ones. An interrupt mask selects which status bits drive the single level-high interrupt.

The register port is a simple single-cycle slave. It is always ready and has no back-pressure. A cycle with `bus_valid` high is an access: a write when `bus_write` is high, otherwise a read. `bus_rdata` shows the addressed register combinationally in every cycle, and a read has effect only when `bus_valid` is high.

Top module: `rtc_regs`

## Requirements
- R1: After reset every register reads 0, busy reads 0 and `irq` is low.
- R2: The sub-second count advances once each time the accumulated slow ticks reach one millisecond. The long-run rate is `SLOW_HZ / MS_PER_SEC` ticks per step. The count wraps from `MS_PER_SEC-1` to 0, and seconds increments on that same cycle.
- R3: Busy (offset 0x004, bit 0) goes high after every `COPY_EVERY`-th slow tick and stays high for exactly `COPY_CYCLES` bus cycles. At the end of that window, seconds (0x008) and milliseconds (0x010) take the running values.
- R4: A read access to milliseconds (0x010) copies the visible seconds value into shadow seconds (0x00C).
- R5: An accepted write to seconds (0x008) loads the running seconds counter and the visible seconds value. The load takes priority over a rollover increment in the same cycle.
- R6: A write issued while busy is high changes no register.
- R7: Seconds alarm 0 (0x014) sets status bit 0, and seconds alarm 1 (0x018) sets status bit 1, on the cycle when seconds increments to equal a nonzero alarm value. An alarm value of 0 never fires.
- R8: The millisecond alarm (0x01C) sets status bit 2 when the sub-second count steps to a nonzero value equal to the alarm.
- R9: Status (0x02C) bits clear only when a one is written to them. A zero leaves a bit unchanged. A new event in the same cycle as a clear wins. Bits 3 and 4 are never set by hardware.
- R10: Status bits set whatever the mask says. The 5-bit mask (0x028) reads back what was written, and uses the same bit layout as status.
- R11: `irq` is high exactly while some status bit and its mask bit are both set.
- R12: Unmapped offsets read 0. Writes to milliseconds, shadow seconds and busy have no effect. Reads other than a milliseconds read change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_in | input | 1 | Asynchronous slow reference clock (nominally 32.768 kHz) |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level-high interrupt |

## Verification
The properties assume the following about the inputs:
- The slow reference input stays high and low for at least three bus cycles each, so that every rising edge yields exactly one tick.
- `MS_PER_SEC` does not exceed `SLOW_HZ`.
- The copy window is shorter than the spacing between copies.

The stimulus drives the slow input with an eight-cycle period. It runs the divider with a small non-integer ratio, so that the tick count per step alternates. Before each intended write it waits for busy to fall, so the write lands in a free window. The dropped-write cases are issued on purpose while busy is high.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int EV_N   = 5;

  // status / mask bit positions (software decodes these)
  localparam int EV_SEC_ALM0 = 0;
  localparam int EV_SEC_ALM1 = 1;
  localparam int EV_MS_ALM   = 2;
  localparam int EV_SEC_CDN  = 3;
  localparam int EV_MS_CDN   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_BUSY   = 6'h04,
    A_SEC    = 6'h08,
    A_SHADOW = 6'h0C,
    A_MSEC   = 6'h10,
    A_ALM0   = 6'h14,
    A_ALM1   = 6'h18,
    A_MSALM  = 6'h1C,
    A_MASK   = 6'h28,
    A_STAT   = 6'h2C
  } reg_addr_e;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int SLOW_HZ     = 32768,
  parameter int MS_PER_SEC  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk_in,
  output logic slow_tick,
  output logic ms_tick
);
  localparam int ACC_W = $clog2(SLOW_HZ + MS_PER_SEC) + 1;

  // synchronizer stages plus one edge-detect flop
  logic [SYNC_STAGES:0] sync_q;
  logic [ACC_W-1:0]     acc_q, acc_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], slow_clk_in};
  end

  assign slow_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // fractional divider: add MS_PER_SEC per tick, step when SLOW_HZ reached
  assign acc_sum = acc_q + ACC_W'(MS_PER_SEC);
  assign ms_tick = slow_tick && (acc_sum >= ACC_W'(SLOW_HZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (ms_tick)   acc_q <= acc_sum - ACC_W'(SLOW_HZ);
    else if (slow_tick) acc_q <= acc_sum;
  end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  parameter int MS_W       = 10,
  parameter int N_SEC_ALM  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ms_tick,
  input  logic                           load_en,
  input  logic [SEC_W-1:0]               load_val,
  input  logic [N_SEC_ALM-1:0][SEC_W-1:0] sec_alarms,
  input  logic [MS_W-1:0]                ms_alarm,
  output logic [SEC_W-1:0]               sec,
  output logic [MS_W-1:0]                msec,
  output logic [N_SEC_ALM:0]             hits
);
  logic            ms_wrap, sec_inc;
  logic [MS_W-1:0] msec_nx;
  logic [SEC_W-1:0] sec_nx;

  assign ms_wrap = ms_tick && (msec == MS_W'(MS_PER_SEC - 1));
  assign msec_nx = ms_wrap ? '0 : msec + 1'b1;
  assign sec_inc = ms_wrap && !load_en;
  assign sec_nx  = sec + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= '0;
      msec <= '0;
    end else begin
      if (ms_tick) msec <= msec_nx;
      if (load_en)      sec <= load_val;
      else if (sec_inc) sec <= sec_nx;
    end
  end

  for (genvar i = 0; i < N_SEC_ALM; i++) begin : g_sec_alm
    assign hits[i] = sec_inc && (sec_alarms[i] != '0) && (sec_nx == sec_alarms[i]);
  end

  assign hits[N_SEC_ALM] = ms_tick && (ms_alarm != '0) && (msec_nx == ms_alarm);
endmodule

// File: rtl/rtc_copy_ctrl.sv
module rtc_copy_ctrl #(
  parameter int COPY_EVERY  = 8,
  parameter int COPY_CYCLES = 4,
  parameter int SEC_W       = 32,
  parameter int MS_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [SEC_W-1:0] sec,
  input  logic [MS_W-1:0]  msec,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_val,
  output logic             busy,
  output logic [SEC_W-1:0] snap_sec,
  output logic [MS_W-1:0]  snap_ms
);
  localparam int PH_W  = (COPY_EVERY > 1) ? $clog2(COPY_EVERY) : 1;
  localparam int CNT_W = $clog2(COPY_CYCLES + 1);

  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] left_q;
  logic             copy_start;

  assign copy_start = slow_tick && (phase_q == PH_W'(COPY_EVERY - 1));
  assign busy       = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      left_q  <= '0;
    end else begin
      if (copy_start)     phase_q <= '0;
      else if (slow_tick) phase_q <= phase_q + 1'b1;
      if (copy_start) left_q <= CNT_W'(COPY_CYCLES);
      else if (busy)  left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_sec <= '0;
      snap_ms  <= '0;
    end else if (load_en) begin
      snap_sec <= load_val;
    end else if (left_q == CNT_W'(1)) begin
      snap_sec <= sec;
      snap_ms  <= msec;
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int SLOW_HZ     = 32768,
  parameter int MS_PER_SEC  = 1000,
  parameter int COPY_EVERY  = 8,
  parameter int COPY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_in,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;

  logic                   slow_tick, ms_tick, busy;
  logic [DATA_W-1:0]      sec, snap_sec, shadow_q;
  logic [MS_W-1:0]        msec, snap_ms, ms_alm_q;
  logic [1:0][DATA_W-1:0] sec_alm;
  logic [2:0]             hits;
  logic [EV_N-1:0]        mask_q, status_q, clr, events;
  logic                   wr_ok, rd_ok, sec_load;

  assign wr_ok    = bus_valid && bus_write && !busy;
  assign rd_ok    = bus_valid && !bus_write;
  assign sec_load = wr_ok && (bus_addr == A_SEC);

  rtc_tick_gen #(.SLOW_HZ(SLOW_HZ), .MS_PER_SEC(MS_PER_SEC), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow_clk_in),
    .slow_tick(slow_tick), .ms_tick(ms_tick)
  );

  rtc_time_count #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(DATA_W), .MS_W(MS_W), .N_SEC_ALM(2)) u_count (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .load_en(sec_load), .load_val(bus_wdata),
    .sec_alarms(sec_alm), .ms_alarm(ms_alm_q),
    .sec(sec), .msec(msec), .hits(hits)
  );

  rtc_copy_ctrl #(.COPY_EVERY(COPY_EVERY), .COPY_CYCLES(COPY_CYCLES), .SEC_W(DATA_W), .MS_W(MS_W)) u_copy (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .sec(sec), .msec(msec), .load_en(sec_load), .load_val(bus_wdata),
    .busy(busy), .snap_sec(snap_sec), .snap_ms(snap_ms)
  );

  assign events = {2'b00, hits};
  assign clr    = (wr_ok && bus_addr == A_STAT) ? bus_wdata[EV_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_alm  <= '0;
      ms_alm_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
      shadow_q <= '0;
    end else begin
      status_q <= (status_q & ~clr) | events;
      if (rd_ok && bus_addr == A_MSEC) shadow_q <= snap_sec;
      if (wr_ok) begin
        case (bus_addr)
          A_ALM0:  sec_alm[0] <= bus_wdata;
          A_ALM1:  sec_alm[1] <= bus_wdata;
          A_MSALM: ms_alm_q   <= bus_wdata[MS_W-1:0];
          A_MASK:  mask_q     <= bus_wdata[EV_N-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BUSY:   bus_rdata = {{(DATA_W-1){1'b0}}, busy};
      A_SEC:    bus_rdata = snap_sec;
      A_SHADOW: bus_rdata = shadow_q;
      A_MSEC:   bus_rdata = {{(DATA_W-MS_W){1'b0}}, snap_ms};
      A_ALM0:   bus_rdata = sec_alm[0];
      A_ALM1:   bus_rdata = sec_alm[1];
      A_MSALM:  bus_rdata = {{(DATA_W-MS_W){1'b0}}, ms_alm_q};
      A_MASK:   bus_rdata = {{(DATA_W-EV_N){1'b0}}, mask_q};
      A_STAT:   bus_rdata = {{(DATA_W-EV_N){1'b0}}, status_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk
  import rtc_pkg::*;
#(
  parameter int MS_PER_SEC  = 1000,
  parameter int COPY_CYCLES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   irq,
  input logic                   busy,
  input logic [EV_N-1:0]        status_q,
  input logic [EV_N-1:0]        mask_q,
  input logic [((MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1)-1:0] msec,
  input logic [1:0][DATA_W-1:0] sec_alm
);
  localparam int MS_W  = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam int RUN_W = $clog2(COPY_CYCLES + 2);

  logic [RUN_W-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_run <= '0;
    else if (!busy)                  busy_run <= '0;
    else if (busy_run != {RUN_W{1'b1}}) busy_run <= busy_run + 1'b1;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < RUN_W'(COPY_CYCLES));

  // R3
  busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R6
  busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && busy && bus_addr == A_MASK) |=> $stable(mask_q));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && !busy && bus_addr == A_STAT)
      |=> (status_q & $past(status_q)) == $past(status_q));

  // R7
  zero_alarm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EV_SEC_ALM0]) |-> $past(sec_alm[0]) != '0);

  // R11
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_valid && bus_write && !busy &&
                         (bus_addr == A_MASK || bus_addr == A_STAT)));

  // R2
  msec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msec != $past(msec)) |-> (msec == MS_W'($past(msec) + 1'b1) || msec == '0));
endmodule

bind rtc_regs rtc_regs_chk #(.MS_PER_SEC(MS_PER_SEC), .COPY_CYCLES(COPY_CYCLES)) u_chk (.*);

// File: tb/test_rtc_regs.sv
module test_rtc_regs;
  import rtc_pkg::*;

  localparam int HZ = 33, MSR = 10, EVERY = 8, COPY = 4;

  logic        clk = 0, rst_n = 0, clk32 = 0;
  logic        b_valid = 0, b_write = 0;
  logic [5:0]  b_addr = 0;
  logic [31:0] b_wdata = 0;
  wire  [31:0] bus_rdata;
  wire         irq;

  always #5 clk = ~clk;
  initial forever #40 clk32 = ~clk32;

  rtc_regs #(.SLOW_HZ(HZ), .MS_PER_SEC(MSR), .COPY_EVERY(EVERY), .COPY_CYCLES(COPY)) i_rtc_regs (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(clk32),
    .bus_valid(b_valid), .bus_write(b_write), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1 = 0, m_s2 = 0, m_s3 = 0, m_acc = 0, m_ms = 0, m_phase = 0, m_left = 0, m_snap_ms = 0;
  int m_msal = 0, m_mask = 0, m_stat = 0;
  logic [31:0] m_sec = 0, m_snap_sec = 0, m_shadow = 0, m_al0 = 0, m_al1 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_acc = 0; m_ms = 0; m_phase = 0; m_left = 0;
      m_snap_ms = 0; m_msal = 0; m_mask = 0; m_stat = 0;
      m_sec = 0; m_snap_sec = 0; m_shadow = 0; m_al0 = 0; m_al1 = 0;
    end else begin
      int tk, mt, ev, clr, o_ms;
      logic [31:0] o_sec, o_snap;
      bit wok, rok;
      tk = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(clk32);
      mt = 0;
      if (tk == 1) begin
        m_acc += MSR;
        if (m_acc >= HZ) begin m_acc -= HZ; mt = 1; end
      end
      wok = b_valid && b_write && (m_left == 0);
      rok = b_valid && !b_write;
      o_sec = m_sec; o_ms = m_ms; o_snap = m_snap_sec;
      ev = 0;
      if (mt == 1) begin
        if (m_ms == MSR - 1) begin
          m_ms = 0;
          if (!(wok && b_addr == 6'h08)) begin
            m_sec = m_sec + 1;
            if (m_al0 != 0 && m_sec == m_al0) ev |= 1;
            if (m_al1 != 0 && m_sec == m_al1) ev |= 2;
          end
        end else m_ms++;
        if (m_msal != 0 && m_ms == m_msal) ev |= 4;
      end
      if (m_left == 1) begin m_snap_sec = o_sec; m_snap_ms = o_ms; end
      if (tk == 1 && m_phase == EVERY - 1) m_left = COPY;
      else if (m_left > 0) m_left--;
      if (tk == 1) m_phase = (m_phase + 1) % EVERY;
      if (rok && b_addr == 6'h10) m_shadow = o_snap;
      clr = 0;
      if (wok) begin
        case (b_addr)
          6'h08: begin m_sec = b_wdata; m_snap_sec = b_wdata; end
          6'h14: m_al0 = b_wdata;
          6'h18: m_al1 = b_wdata;
          6'h1C: m_msal = int'(b_wdata & 32'hF);
          6'h28: m_mask = int'(b_wdata & 32'h1F);
          6'h2C: clr = int'(b_wdata & 32'h1F);
          default: ;
        endcase
      end
      m_stat = ((m_stat & ~clr) | ev) & 31;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h04: return (m_left > 0) ? 32'd1 : 32'd0;
      6'h08: return m_snap_sec;
      6'h0C: return m_shadow;
      6'h10: return 32'(m_snap_ms);
      6'h14: return m_al0;
      6'h18: return m_al1;
      6'h1C: return 32'(m_msal);
      6'h28: return 32'(m_mask);
      6'h2C: return 32'(m_stat);
      default: return 32'd0;
    endcase
  endfunction

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  string cur_tag = "R1";
  logic [31:0] last_rd = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    b_valid = v; b_write = w; b_addr = a; b_wdata = d;
    #1;
    last_rd = bus_rdata;
    check(cur_tag, bus_rdata, exp_rd(a));
    check("R11", {31'b0, irq}, {31'b0, ((m_stat & m_mask) != 0)});
  endtask

  task automatic rd(input logic [5:0] a);  cyc(1'b1, 1'b0, a, 32'd0); endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask

  task automatic wait_busy_rise();
    do rd(A_BUSY); while (last_rd[0]);
    do rd(A_BUSY); while (!last_rd[0]);
  endtask

  task automatic wr_safe(input logic [5:0] a, input logic [31:0] d);
    wait_busy_rise();
    do rd(A_BUSY); while (last_rd[0]);
    wr(a, d);
  endtask

  task automatic wait_sec(input logic [31:0] n);
    do rd(A_SEC); while (last_rd < n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    cur_tag = "R1";
    rd(A_BUSY); rd(A_SEC); rd(A_SHADOW); rd(A_MSEC); rd(A_ALM0);
    rd(A_ALM1); rd(A_MSALM); rd(A_MASK); rd(A_STAT);
    check("R1", last_rd, 32'd0);
    check("R1", {31'b0, irq}, 32'd0);

    // R12 unmapped offset
    cur_tag = "R12";
    rd(6'h20);
    check("R12", last_rd, 32'd0);

    // R7 / R8 alarm setup
    cur_tag = "R7";
    wr_safe(A_ALM0, 32'd3);
    wr_safe(A_ALM1, 32'd0);
    cur_tag = "R8";
    wr_safe(A_MSALM, 32'd5);

    // R2 / R3 time advance
    cur_tag = "R2";
    wait_sec(32'd4);

    // R4 shadow coherent with milliseconds read
    cur_tag = "R4";
    wait_busy_rise();
    do rd(A_BUSY); while (last_rd[0]);
    rd(A_SEC); s = last_rd;
    rd(A_MSEC);
    rd(A_SHADOW);
    check("R4", last_rd, s);

    // R10 status sets with mask clear
    cur_tag = "R10";
    rd(A_STAT);
    check("R10", {31'b0, last_rd[0]}, 32'd1);
    check("R7",  {31'b0, last_rd[1]}, 32'd0);
    check("R8",  {31'b0, last_rd[2]}, 32'd1);
    check("R10", {31'b0, irq}, 32'd0);

    // R11 unmasking drives irq
    cur_tag = "R11";
    wr_safe(A_MASK, 32'd1);
    rd(A_MASK);
    check("R11", {31'b0, irq}, 32'd1);

    // R9 write-one-to-clear
    cur_tag = "R9";
    wr_safe(A_STAT, 32'd0);
    rd(A_STAT);
    check("R9", {31'b0, last_rd[0]}, 32'd1);
    wr_safe(A_STAT, 32'd1);
    rd(A_STAT);
    check("R9", {31'b0, last_rd[0]}, 32'd0);
    check("R9", {31'b0, irq}, 32'd0);
    wr_safe(A_STAT, 32'h18);
    rd(A_STAT);

    // R6 writes dropped while busy
    cur_tag = "R6";
    wait_busy_rise();
    wr(A_MASK, 32'h1F);
    rd(A_MASK);
    check("R6", last_rd, 32'd1);
    wait_busy_rise();
    wr(A_ALM0, 32'd77);
    rd(A_ALM0);
    check("R6", last_rd, 32'd3);

    // R5 seconds load
    cur_tag = "R5";
    wr_safe(A_SEC, 32'd100);
    rd(A_SEC);
    check("R5", last_rd, 32'd100);

    // R12 read-only registers ignore writes
    cur_tag = "R12";
    wr_safe(A_MSEC, 32'd7);
    wr_safe(A_SHADOW, 32'hDEAD);
    wr_safe(A_BUSY, 32'd1);
    rd(A_SHADOW);

    // R7 alarm 1 fires
    cur_tag = "R7";
    wr_safe(A_ALM1, 32'd102);
    wait_sec(32'd103);
    rd(A_STAT);
    check("R7", {31'b0, last_rd[1]}, 32'd1);

    // R3 copy window cadence
    cur_tag = "R3";
    repeat (200) rd(A_BUSY);

    done = 1;
    summary();
    $finish;
  end
endmodule